// File: doc/BRIEF.md
# Maskable Interrupt Request Conditioner

This block takes the interrupt pins of a small microcontroller core and turns them into one request towards the CPU sequencer. The request comes with a vector index. The pins are:

- an active-low IRQ line;
- an active-low non-maskable XIRQ line;
- a set of auxiliary edge inputs;
- a handshake strobe pin.

Every pin is asynchronous and passes through a two-flop synchronizer. The IRQ line works in one of two modes. In level mode, any number of open-drain sources can share the line, and the request follows the line while it is held low. In edge mode, a falling edge sets a pending flag. The mode bit is locked once a fixed number of cycles has passed after reset.

The core drives a few strobes into the block: mask set, mask clear, condition-code restore, instruction boundary and acknowledge. From these the block keeps its own copy of the interrupt mask. A mask clear does not release maskable requests until the instruction boundary that follows it has passed. A condition-code restore takes effect on the next cycle. XIRQ bypasses the mask. A simple register write port sets the auxiliary edge selects and enables, and clears pending flags by writing ones.

Top module: `intreq_cond`

## Requirements
- R1: After reset the effective mask reads 1, IRQ is in level mode, every auxiliary edge select is 0 and every enable is 0, no flag is pending, `int_req` is 0 and `vec_id` is 0.
- R2: In level mode (mode bit 0), a low IRQ raises a maskable request with vector 1 two clock edges after the pin falls. The request stays while the pin stays low, an acknowledge does not remove it, and it drops two edges after the pin rises.
- R3: In edge mode (mode bit 1), a falling IRQ edge sets a pending flag that shows as vector 1 three edges after the pin falls. The flag stays after the pin returns high. It is cleared by an acknowledge of vector 1 or by writing 1 to clear bit 0.
- R4: The mode bit (register 0, bit 0) is written only while fewer than `WIN` (default 64) cycles have passed since reset was released. Later writes leave it unchanged.
- R5: A mask-set strobe makes `mask_eff` 1 from the next cycle. While `mask_eff` is 1, only XIRQ can raise `int_req`.
- R6: After a mask-clear strobe, `mask_eff` stays 1 up to and including the cycle in which the next instruction-boundary strobe is seen. It becomes 0 on the cycle after that boundary, so no maskable request is visible at that boundary.
- R7: A condition-code restore strobe loads the mask from `ccr_mask` with effect on the next cycle. It does not wait for any boundary.
- R8: A low XIRQ raises `int_req` with vector 0 two edges after the pin falls, whatever the mask is.
- R9: Each auxiliary input i has an edge select in register 1, bit i (0 = rising, 1 = falling) and an enable in register 2, bit i. The selected edge sets its pending flag and the other edge does not. The flag requests vector 2+i only while it is enabled, three edges after the pin change.
- R10: The strobe pin latches on a falling edge and requests vector `NAUX`+2 (6 by default) only while `single_chip` is 1. While `single_chip` is 0 it never requests.
- R11: When several requests are active, `vec_id` gives the lowest index: XIRQ (0), then IRQ (1), then auxiliary inputs in ascending order, then the strobe. With no request, `vec_id` is 0.
- R12: A write to register 3 clears, for every bit written as 1, one pending flag: bit 0 is IRQ, bit 1+i is auxiliary input i, and bit `NAUX`+1 is the strobe. An acknowledge with `ack_vec` equal to a source's vector clears that source's flag. Both take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 1 | Maskable interrupt pin, active low, asynchronous |
| xirq_n | input | 1 | Non-maskable interrupt pin, active low, asynchronous |
| aux_in | input | NAUX | Auxiliary edge interrupt pins, asynchronous |
| strb_in | input | 1 | Handshake strobe pin, falling-edge source, asynchronous |
| single_chip | input | 1 | Operating mode; 1 lets the strobe pin act as a source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 edge select, 2 enable, 3 clear |
| wr_data | input | NAUX+2 | Register write data |
| mask_set | input | 1 | Core strobe: mask-set instruction |
| mask_clr | input | 1 | Core strobe: mask-clear instruction completes |
| ccr_load | input | 1 | Core strobe: condition codes restored |
| ccr_mask | input | 1 | Mask value carried by the restore |
| insn_bnd | input | 1 | Core strobe: instruction boundary |
| ack | input | 1 | Core strobe: interrupt acknowledged |
| ack_vec | input | $clog2(NAUX+3) | Vector being acknowledged |
| int_req | output | 1 | Interrupt request to the sequencer |
| vec_id | output | $clog2(NAUX+3) | Vector index of the winning request |
| mask_eff | output | 1 | Effective interrupt mask |

## Verification
Level requests (IRQ, XIRQ) are due two rising edges after a pin change, and edge-latched flags are due three. Register writes, acknowledges and mask strobes act after a single edge. The bench changes pins and strobes on the falling clock edge and counts whole cycles from there to the one where the result is due. At level latency it also checks one cycle early, to show that the synchronizer delay is really there. The delayed unmask is checked on both sides of the boundary strobe: with IRQ held low, the mask reads 1 while the boundary is presented and 0 one edge later.

// File: rtl/intreq_pkg.sv
package intreq_pkg;

    // register select on the write port
    typedef enum logic [1:0] {
        SEL_MODE  = 2'd0,
        SEL_EDGE  = 2'd1,
        SEL_ENA   = 2'd2,
        SEL_CLEAR = 2'd3
    } reg_sel_e;

    // core strobes that steer the interrupt mask
    typedef struct packed {
        logic set;
        logic clr;
        logic load;
        logic load_val;
        logic bnd;
    } mask_cmd_t;

    localparam int SRC_XIRQ = 0;
    localparam int SRC_IRQ  = 1;
    localparam int SRC_AUX0 = 2;

    function automatic int src_strobe(input int naux);
        return SRC_AUX0 + naux;
    endfunction

    function automatic int clr_bit_aux(input int idx);
        return 1 + idx;
    endfunction

    function automatic int clr_bit_strobe(input int naux);
        return 1 + naux;
    endfunction

endpackage

// File: rtl/intreq_sync.sv
module intreq_sync #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/intreq_edge.sv
module intreq_edge (
    input  logic clk,
    input  logic rst,
    input  logic s,
    input  logic fall_sel,
    input  logic arm,
    input  logic clr,
    output logic pend
);
    logic prev;
    logic hit;

    always_comb begin
        if (fall_sel) hit = prev & ~s;
        else          hit = ~prev & s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b1;
            pend <= 1'b0;
        end else begin
            prev <= s;
            if (arm && hit) pend <= 1'b1;
            else if (clr)   pend <= 1'b0;
        end
    end

    // R9
    disarmed_chk: assert property (@(posedge clk) disable iff (rst)
        !arm |=> !$rose(pend));

    // R12
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr && !arm |=> !pend);
endmodule

// File: rtl/intreq_cfg.sv
module intreq_cfg #(
    parameter int WIN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic wval,
    output logic edge_mode
);
    localparam int CW = $clog2(WIN + 1);

    logic [CW-1:0] age;
    logic          open_win;

    assign open_win = (age < CW'(WIN));

    always_ff @(posedge clk) begin
        if (rst)           age <= '0;
        else if (open_win) age <= age + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)                  edge_mode <= 1'b0;
        else if (wr && open_win)  edge_mode <= wval;
    end

    // R4
    mode_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !open_win && wr |=> $stable(edge_mode));
endmodule

// File: rtl/intreq_mask.sv
module intreq_mask
    import intreq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  mask_cmd_t cmd,
    output logic      mask_eff
);
    logic mask_q;
    logic hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= 1'b1;
            hold_q <= 1'b0;
        end else if (cmd.load) begin
            mask_q <= cmd.load_val;
            hold_q <= 1'b0;
        end else if (cmd.set) begin
            mask_q <= 1'b1;
            hold_q <= 1'b0;
        end else if (cmd.clr) begin
            mask_q <= 1'b0;
            hold_q <= 1'b1;
        end else if (cmd.bnd) begin
            hold_q <= 1'b0;
        end
    end

    assign mask_eff = mask_q | hold_q;

    // R5
    set_takes_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.set && !cmd.load |=> mask_eff);

    // R6
    unmask_delay_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.clr && !cmd.load && !cmd.set |=> mask_eff);

    // R6
    unmask_release_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.bnd && !cmd.load && !cmd.set && !cmd.clr && !mask_q |=> !mask_eff);

    // R7
    restore_chk: assert property (@(posedge clk) disable iff (rst)
        cmd.load |=> mask_eff == $past(cmd.load_val));
endmodule

// File: rtl/intreq_cond.sv
module intreq_cond
    import intreq_pkg::*;
#(
    parameter  int NAUX = 4,
    parameter  int WIN  = 64,
    localparam int NSRC = NAUX + 3,
    localparam int VW   = $clog2(NSRC),
    localparam int DW   = NAUX + 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_n,
    input  logic            xirq_n,
    input  logic [NAUX-1:0] aux_in,
    input  logic            strb_in,
    input  logic            single_chip,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            mask_set,
    input  logic            mask_clr,
    input  logic            ccr_load,
    input  logic            ccr_mask,
    input  logic            insn_bnd,
    input  logic            ack,
    input  logic [VW-1:0]   ack_vec,
    output logic            int_req,
    output logic [VW-1:0]   vec_id,
    output logic            mask_eff
);
    localparam int NPIN = NAUX + 3;
    localparam int STRB = src_strobe(NAUX);

    // synchronized pins: {strobe, aux, irq, xirq}
    logic [NPIN-1:0] pin_raw;
    logic [NPIN-1:0] pin_s;
    logic            xirq_s;
    logic            irq_s;
    logic [NAUX-1:0] aux_s;
    logic            strb_s;

    assign pin_raw = {strb_in, aux_in, irq_n, xirq_n};

    intreq_sync #(.W(NPIN), .RST_VAL({NPIN{1'b1}})) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    assign xirq_s = pin_s[0];
    assign irq_s  = pin_s[1];
    assign aux_s  = pin_s[NAUX+1:2];
    assign strb_s = pin_s[NPIN-1];

    // write decode
    reg_sel_e        sel;
    logic [DW-1:0]   clr_w;
    logic [NAUX-1:0] edge_sel;
    logic [NAUX-1:0] aux_ena;

    assign sel   = reg_sel_e'(wr_addr);
    assign clr_w = (wr_en && sel == SEL_CLEAR) ? wr_data : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            edge_sel <= '0;
            aux_ena  <= '0;
        end else if (wr_en) begin
            if (sel == SEL_EDGE) edge_sel <= wr_data[NAUX-1:0];
            if (sel == SEL_ENA)  aux_ena  <= wr_data[NAUX-1:0];
        end
    end

    // acknowledge decode
    logic [NSRC-1:0] ack_hit;

    always_comb begin
        for (int k = 0; k < NSRC; k++) begin
            ack_hit[k] = ack && (ack_vec == VW'(k));
        end
    end

    // IRQ mode bit with its write window
    logic edge_mode;

    intreq_cfg #(.WIN(WIN)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .wr        (wr_en && sel == SEL_MODE),
        .wval      (wr_data[0]),
        .edge_mode (edge_mode)
    );

    // mask tracking
    mask_cmd_t mcmd;

    assign mcmd = '{set: mask_set, clr: mask_clr, load: ccr_load,
                    load_val: ccr_mask, bnd: insn_bnd};

    intreq_mask u_mask (
        .clk      (clk),
        .rst      (rst),
        .cmd      (mcmd),
        .mask_eff (mask_eff)
    );

    // pending flags
    logic            irq_pend;
    logic [NAUX-1:0] aux_pend;
    logic            strb_pend;

    intreq_edge u_irq_edge (
        .clk      (clk),
        .rst      (rst),
        .s        (irq_s),
        .fall_sel (1'b1),
        .arm      (edge_mode),
        .clr      (clr_w[0] | ack_hit[SRC_IRQ] | ~edge_mode),
        .pend     (irq_pend)
    );

    for (genvar i = 0; i < NAUX; i++) begin : g_aux
        intreq_edge u_aux_edge (
            .clk      (clk),
            .rst      (rst),
            .s        (aux_s[i]),
            .fall_sel (edge_sel[i]),
            .arm      (1'b1),
            .clr      (clr_w[clr_bit_aux(i)] | ack_hit[SRC_AUX0+i]),
            .pend     (aux_pend[i])
        );
    end

    intreq_edge u_strb_edge (
        .clk      (clk),
        .rst      (rst),
        .s        (strb_s),
        .fall_sel (1'b1),
        .arm      (single_chip),
        .clr      (clr_w[clr_bit_strobe(NAUX)] | ack_hit[STRB] | ~single_chip),
        .pend     (strb_pend)
    );

    // source requests and fixed priority
    logic [NSRC-1:0] src_req;
    logic            irq_raw;

    assign irq_raw = edge_mode ? irq_pend : ~irq_s;

    always_comb begin
        src_req                        = '0;
        src_req[SRC_XIRQ]              = ~xirq_s;
        src_req[SRC_IRQ]               = irq_raw & ~mask_eff;
        src_req[SRC_AUX0 +: NAUX]      = aux_pend & aux_ena & {NAUX{~mask_eff}};
        src_req[STRB]                  = strb_pend & single_chip & ~mask_eff;
    end

    always_comb begin
        vec_id = '0;
        for (int k = NSRC - 1; k >= 0; k--) begin
            if (src_req[k]) vec_id = VW'(k);
        end
    end

    assign int_req = |src_req;

    // R8
    xirq_pass_chk: assert property (@(posedge clk) disable iff (rst)
        !xirq_s |-> int_req && vec_id == '0);

    // R5
    masked_only_xirq_chk: assert property (@(posedge clk) disable iff (rst)
        mask_eff && int_req |-> vec_id == '0);

    // R10
    strobe_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !single_chip |-> !(int_req && vec_id == VW'(STRB)));

    // R11
    irq_over_aux_chk: assert property (@(posedge clk) disable iff (rst)
        xirq_s && irq_raw && !mask_eff |-> vec_id == VW'(SRC_IRQ));
endmodule

// File: tb/test_intreq_cond.sv
module test_intreq_cond;
    localparam int NAUX = 4;
    localparam int VW   = 3;
    localparam int DW   = NAUX + 2;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            irq_n = 1'b1;
    logic            xirq_n = 1'b1;
    logic [NAUX-1:0] aux_in = '1;
    logic            strb_in = 1'b1;
    logic            single_chip = 1'b0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_addr = '0;
    logic [DW-1:0]   wr_data = '0;
    logic            mask_set = 1'b0;
    logic            mask_clr = 1'b0;
    logic            ccr_load = 1'b0;
    logic            ccr_mask = 1'b0;
    logic            insn_bnd = 1'b0;
    logic            ack = 1'b0;
    logic [VW-1:0]   ack_vec = '0;
    logic            int_req;
    logic [VW-1:0]   vec_id;
    logic            mask_eff;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    intreq_cond i_intreq_cond (
        .clk(clk), .rst(rst), .irq_n(irq_n), .xirq_n(xirq_n), .aux_in(aux_in),
        .strb_in(strb_in), .single_chip(single_chip), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .mask_set(mask_set),
        .mask_clr(mask_clr), .ccr_load(ccr_load), .ccr_mask(ccr_mask),
        .insn_bnd(insn_bnd), .ack(ack), .ack_vec(ack_vec),
        .int_req(int_req), .vec_id(vec_id), .mask_eff(mask_eff)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(1);
        wr_en = 1'b0;
    endtask

    task automatic do_ack(input logic [VW-1:0] v);
        ack = 1'b1; ack_vec = v;
        tick(1);
        ack = 1'b0;
    endtask

    task automatic do_restore(input logic v);
        ccr_load = 1'b1; ccr_mask = v;
        tick(1);
        ccr_load = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        irq_n = 1'b1; xirq_n = 1'b1; aux_in = '1; strb_in = 1'b1;
        tick(3);
        rst = 1'b0;
        check("R1 int_req", int_req, 0);
        check("R1 vec_id", vec_id, 0);
        check("R1 mask_eff", mask_eff, 1);
    endtask

    task automatic t_unmask();
        irq_n = 1'b0;
        tick(3);
        check("R1 masked level irq", int_req, 0);
        mask_clr = 1'b1;
        tick(1);
        mask_clr = 1'b0;
        check("R6 mask held after clear", mask_eff, 1);
        tick(2);
        check("R6 held until boundary", mask_eff, 1);
        check("R6 no request before boundary", int_req, 0);
        insn_bnd = 1'b1;
        #1;
        check("R6 held at boundary", mask_eff, 1);
        check("R6 no request at boundary", int_req, 0);
        tick(1);
        insn_bnd = 1'b0;
        check("R6 released after boundary", mask_eff, 0);
        check("R6 request after boundary", int_req, 1);
        irq_n = 1'b1;
        tick(2);
        check("R2 level drops after release", int_req, 0);
    endtask

    task automatic t_level();
        irq_n = 1'b0;
        tick(1);
        check("R2 not yet after one edge", int_req, 0);
        tick(1);
        check("R2 level request", int_req, 1);
        check("R2 level vector", vec_id, 1);
        do_ack(3'd1);
        tick(2);
        check("R2 ack does not clear level", int_req, 1);
        irq_n = 1'b1;
        tick(1);
        check("R2 still high one edge after release", int_req, 1);
        tick(1);
        check("R2 released", int_req, 0);
    endtask

    task automatic t_mask_xirq();
        irq_n = 1'b0;
        tick(2);
        check("R2 request before mask set", int_req, 1);
        mask_set = 1'b1;
        tick(1);
        mask_set = 1'b0;
        check("R5 mask set next cycle", mask_eff, 1);
        check("R5 masked irq", int_req, 0);
        do_restore(1'b0);
        check("R7 restore immediate", mask_eff, 0);
        check("R7 request after restore", int_req, 1);
        do_restore(1'b1);
        check("R7 restore sets mask", mask_eff, 1);
        xirq_n = 1'b0;
        tick(1);
        check("R8 not yet", int_req, 0);
        tick(1);
        check("R8 xirq through mask", int_req, 1);
        check("R8 xirq vector", vec_id, 0);
        do_restore(1'b0);
        check("R11 xirq over irq", vec_id, 0);
        xirq_n = 1'b1;
        tick(2);
        check("R11 irq after xirq gone", vec_id, 1);
        irq_n = 1'b1;
        tick(2);
        check("R2 idle", int_req, 0);
    endtask

    task automatic t_window_closed_level();
        tick(70);
        wr_reg(2'd0, 6'd1);
        irq_n = 1'b0;
        tick(1);
        irq_n = 1'b1;
        tick(5);
        check("R4 late write ignored, still level", int_req, 0);
    endtask

    task automatic t_aux();
        wr_reg(2'd1, 6'b000010);
        wr_reg(2'd2, 6'b000011);
        aux_in[1] = 1'b0;
        tick(2);
        check("R9 edge not yet", int_req, 0);
        tick(1);
        check("R9 aux1 falling request", int_req, 1);
        check("R9 aux1 vector", vec_id, 3);
        aux_in[1] = 1'b1;
        tick(4);
        check("R9 aux1 held after pin", vec_id, 3);
        wr_reg(2'd3, 6'b000100);
        check("R12 clear bit 2 removes aux1", int_req, 0);
        aux_in[0] = 1'b0;
        tick(4);
        check("R9 wrong edge ignored", int_req, 0);
        aux_in[0] = 1'b1;
        tick(3);
        check("R9 aux0 rising request", vec_id, 2);
        aux_in[1] = 1'b0;
        tick(3);
        check("R11 aux0 over aux1", vec_id, 2);
        do_ack(3'd2);
        check("R12 ack aux0", vec_id, 3);
        do_ack(3'd3);
        check("R12 ack aux1", int_req, 0);
        aux_in[1] = 1'b1;
        aux_in[2] = 1'b0;
        tick(2);
        aux_in[2] = 1'b1;
        tick(4);
        check("R9 disabled aux2 silent", int_req, 0);
        wr_reg(2'd3, 6'b001000);
        tick(2);
    endtask

    task automatic t_strobe();
        single_chip = 1'b0;
        strb_in = 1'b0;
        tick(2);
        strb_in = 1'b1;
        tick(4);
        check("R10 strobe ignored outside single-chip", int_req, 0);
        single_chip = 1'b1;
        tick(1);
        strb_in = 1'b0;
        tick(3);
        check("R10 strobe request", int_req, 1);
        check("R10 strobe vector", vec_id, 6);
        irq_n = 1'b0;
        tick(2);
        check("R11 irq over strobe", vec_id, 1);
        irq_n = 1'b1;
        tick(2);
        check("R11 strobe after irq", vec_id, 6);
        strb_in = 1'b1;
        wr_reg(2'd3, 6'b100000);
        check("R12 clear strobe", int_req, 0);
        single_chip = 1'b0;
    endtask

    task automatic t_edge();
        t_reset();
        wr_reg(2'd0, 6'd1);
        do_restore(1'b0);
        irq_n = 1'b0;
        tick(1);
        irq_n = 1'b1;
        tick(1);
        check("R3 not yet", int_req, 0);
        tick(1);
        check("R3 edge latched", int_req, 1);
        check("R3 vector", vec_id, 1);
        tick(4);
        check("R3 latched after pin high", int_req, 1);
        do_ack(3'd1);
        check("R3 ack clears", int_req, 0);
        irq_n = 1'b0;
        tick(1);
        irq_n = 1'b1;
        tick(2);
        check("R3 second edge", int_req, 1);
        wr_reg(2'd3, 6'b000001);
        check("R12 clear bit 0", int_req, 0);
        tick(70);
        wr_reg(2'd0, 6'd0);
        irq_n = 1'b0;
        tick(1);
        irq_n = 1'b1;
        tick(5);
        check("R4 late write ignored, still edge", int_req, 1);
        wr_reg(2'd3, 6'b000001);
    endtask

    initial begin
        t_reset();
        t_unmask();
        t_level();
        t_mask_xirq();
        t_window_closed_level();
        t_aux();
        t_strobe();
        t_edge();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule